// File: doc/BRIEF.md
# Seven-Level Level-Shifted PWM Gate Generator

This block drives the seven power switches of a single-phase seven-level inverter. The inverter is built from a three-segment level stage, which sets the output magnitude, and a four-switch bridge, which sets the sign or forces the zero state. Each clock the block takes a signed reference sample. It folds the sample to its magnitude and compares that magnitude with three triangle carriers. The carriers share one phase, frequency and amplitude and are stacked into the lower, middle and upper thirds of full scale. The number of carriers that the magnitude exceeds gives a level code from 0 to 3. That code switches on exactly one segment gate. The sign of the sample picks the bridge diagonal.

Each bridge leg is a complementary pair. Whenever the conducting switch of a leg changes, both switches are held off for a programmable dead interval first. After reset every gate stays low until the first carrier period is complete. The carrier period, the dead interval and the sample width are parameters. The defaults give a 10 kHz carrier and 2 µs of dead time at a 100 MHz clock.

Top module: `lspwm7_gate_gen`

## Requirements
- R1: While reset is high, and afterwards until the internal carrier counter has wrapped once (PERIOD cycles after reset is released), all seven gate outputs are low.
- R2: The carrier counter runs 0..PERIOD-1 (PERIOD even, H = PERIOD/2). Its triangle phase is t = c for c <= H and t = PERIOD - c otherwise. The level code is the number of k in {0,1,2} for which mag·3H > (k·H + t)·2^(REF_W-1). Equality counts as not exceeding.
- R3: `seg_gate` bit k-1 is high exactly when the level code is k (k = 1..3), and all bits are low for code 0. At most one bit is ever high.
- R4: `ref_sample` is two's complement. Its magnitude is used, so +v and -v give the same segment pattern, and the most negative code gives magnitude 2^(REF_W-1).
- R5: `bridge_gate` bit 0 = A-high, bit 1 = A-low, bit 2 = B-high, bit 3 = B-low. For a non-zero level code with a positive (or zero) sample, the settled bridge is 4'b1001. With a negative sample it is 4'b0110.
- R6: For level code 0 the settled bridge is 4'b1010 (both low switches on, which shorts the load).
- R7: The two switches of one leg are never on together. When the conducting switch of a leg changes, both are off for exactly DEAD cycles before the other switch turns on.
- R8: The two high-side bridge switches are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sample | input | REF_W | Signed reference sample, read every clock |
| seg_gate | output | 3 | One-hot level-stage gates, bit k-1 for level k |
| bridge_gate | output | 4 | Bridge gates {B-low, B-high, A-low, A-high} |

## Verification
On every cycle the assertions check four things. The segment gates are one-hot or idle. No leg has both switches on, and the two high sides are never on together. Every handover inside a leg is preceded by at least DEAD all-off cycles. All gates stay low until the block is armed. The scenarios show what no single-cycle property can. They count segment on-time over whole carrier periods and compare it with the stacked-carrier rule, including the equality cases and the most negative sample. They check that mirrored samples give the same pattern, that the settled diagonal and zero states are correct, and that a sign reversal produces a dead gap of exactly DEAD cycles on both legs.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

  localparam int NUM_BANDS = 3;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_drive_t;

  // Level code to one-hot segment enable; code 0 enables nothing.
  function automatic logic [NUM_BANDS-1:0] seg_onehot(input logic [1:0] lvl);
    logic [NUM_BANDS-1:0] v;
    v = '0;
    if (lvl != 2'd0) v[lvl - 2'd1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/lspwm_carrier.sv
module lspwm_carrier #(
  parameter int PERIOD = 10000
) (
  input  logic                           clk,
  input  logic                           rst,
  output logic [$clog2(PERIOD/2+1)-1:0]  tri_ph,
  output logic                           armed
);
  localparam int HALF  = PERIOD / 2;
  localparam int CNT_W = $clog2(PERIOD);
  localparam int T_W   = $clog2(HALF + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (cnt == CNT_W'(PERIOD - 1)) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Symmetric triangle: rises 0..HALF, then falls back toward 1.
  always_comb begin
    if (cnt <= CNT_W'(HALF)) tri_ph = T_W'(cnt);
    else                     tri_ph = T_W'(CNT_W'(PERIOD) - cnt);
  end

endmodule

// File: rtl/lspwm_level_cmp.sv
module lspwm_level_cmp import lspwm_pkg::*; #(
  parameter int REF_W  = 16,
  parameter int PERIOD = 10000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [REF_W-1:0]               ref_sample,
  input  logic [$clog2(PERIOD/2+1)-1:0]  tri_ph,
  output logic [1:0]                     level,
  output logic                           neg
);
  localparam int HALF  = PERIOD / 2;
  localparam int CMP_W = REF_W + $clog2(3 * HALF + 1) + 2;

  logic [REF_W-1:0]     mag;
  logic [CMP_W-1:0]     lhs;
  logic [NUM_BANDS-1:0] above;

  // Fold to magnitude; the most negative code maps to 2^(REF_W-1).
  always_comb begin
    if (ref_sample[REF_W-1]) mag = REF_W'(~ref_sample + 1'b1);
    else                     mag = ref_sample;
    lhs = CMP_W'(mag) * CMP_W'(3 * HALF);
  end

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    logic [CMP_W-1:0] rhs;
    always_comb begin
      rhs      = (CMP_W'(k * HALF) + CMP_W'(tri_ph)) << (REF_W - 1);
      above[k] = (lhs > rhs);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 2'd0;
      neg   <= 1'b0;
    end else begin
      level <= {1'b0, above[0]} + {1'b0, above[1]} + {1'b0, above[2]};
      neg   <= ref_sample[REF_W-1];
    end
  end

endmodule

// File: rtl/lspwm_dead_leg.sv
module lspwm_dead_leg import lspwm_pkg::*; #(
  parameter int DEAD = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  leg_drive_t want,
  output logic       hi,
  output logic       lo
);
  localparam int TW = $clog2(DEAD + 1);

  leg_drive_t    held;
  logic [TW-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= LEG_OFF;
      timer <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else if (want != held) begin
      held  <= want;
      timer <= TW'(DEAD - 1);
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end else begin
      hi <= (held == LEG_HI);
      lo <= (held == LEG_LO);
    end
  end

endmodule

// File: rtl/lspwm7_gate_gen.sv
module lspwm7_gate_gen import lspwm_pkg::*; #(
  parameter int REF_W  = 16,
  parameter int PERIOD = 10000,
  parameter int DEAD   = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] ref_sample,
  output logic [2:0]       seg_gate,
  output logic [3:0]       bridge_gate
);
  localparam int T_W = $clog2(PERIOD / 2 + 1);

  logic [T_W-1:0] tri_ph;
  logic           armed;
  logic [1:0]     level_q;
  logic           neg_q;
  leg_drive_t     want [2];
  logic [1:0]     leg_hi, leg_lo;

  lspwm_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk(clk), .rst(rst), .tri_ph(tri_ph), .armed(armed)
  );

  lspwm_level_cmp #(.REF_W(REF_W), .PERIOD(PERIOD)) u_cmp (
    .clk(clk), .rst(rst), .ref_sample(ref_sample), .tri_ph(tri_ph),
    .level(level_q), .neg(neg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) seg_gate <= '0;
    else     seg_gate <= armed ? seg_onehot(level_q) : '0;
  end

  // Leg A carries the positive diagonal high side, leg B the negative one.
  always_comb begin
    if (!armed) begin
      want[0] = LEG_OFF;
      want[1] = LEG_OFF;
    end else if (level_q == 2'd0) begin
      want[0] = LEG_LO;
      want[1] = LEG_LO;
    end else begin
      want[0] = neg_q ? LEG_LO : LEG_HI;
      want[1] = neg_q ? LEG_HI : LEG_LO;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    lspwm_dead_leg #(.DEAD(DEAD)) u_leg (
      .clk(clk), .rst(rst), .want(want[g]), .hi(leg_hi[g]), .lo(leg_lo[g])
    );
  end

  assign bridge_gate = {leg_lo[1], leg_hi[1], leg_lo[0], leg_hi[0]};

endmodule

// File: rtl/lspwm7_gate_chk.sv
module lspwm7_gate_chk #(
  parameter int DEAD = 200
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] seg_gate,
  input logic [3:0] bridge_gate,
  input logic       armed
);
  localparam int DW = $clog2(DEAD + 2);

  logic [1:0] hi_s, lo_s;
  assign hi_s = {bridge_gate[2], bridge_gate[0]};
  assign lo_s = {bridge_gate[3], bridge_gate[1]};

  assert_gates_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (seg_gate == 3'b000 && bridge_gate == 4'b0000));

  assert_seg_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_gate));

  assert_high_sides_R8: assert property (@(posedge clk) disable iff (rst)
    !(bridge_gate[0] && bridge_gate[2]));

  for (genvar l = 0; l < 2; l++) begin : g_leg
    logic [DW-1:0] off_run;
    logic          last_hi, last_lo;

    always_ff @(posedge clk) begin
      if (rst) begin
        off_run <= '0;
        last_hi <= 1'b0;
        last_lo <= 1'b0;
      end else begin
        if (!hi_s[l] && !lo_s[l]) begin
          if (off_run != DW'(DEAD)) off_run <= off_run + 1'b1;
        end else begin
          off_run <= '0;
        end
        if (hi_s[l]) begin last_hi <= 1'b1; last_lo <= 1'b0; end
        if (lo_s[l]) begin last_hi <= 1'b0; last_lo <= 1'b1; end
      end
    end

    assert_leg_excl_R7: assert property (@(posedge clk) disable iff (rst)
      !(hi_s[l] && lo_s[l]));

    assert_dead_lo_R7: assert property (@(posedge clk) disable iff (rst)
      ($rose(lo_s[l]) && last_hi) |-> (off_run >= DW'(DEAD)));

    assert_dead_hi_R7: assert property (@(posedge clk) disable iff (rst)
      ($rose(hi_s[l]) && last_lo) |-> (off_run >= DW'(DEAD)));
  end

endmodule

bind lspwm7_gate_gen lspwm7_gate_chk #(.DEAD(DEAD)) u_gate_chk (
  .clk(clk), .rst(rst), .seg_gate(seg_gate), .bridge_gate(bridge_gate),
  .armed(armed)
);

// File: tb/test_lspwm7_gate_gen.sv
module test_lspwm7_gate_gen;
  localparam int REF_W  = 8;
  localparam int PERIOD = 24;
  localparam int DEAD   = 3;
  localparam int HALF   = PERIOD / 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [7:0] ref_s = '0;
  logic [2:0]        seg_gate;
  logic [3:0]        bridge_gate;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  lspwm7_gate_gen #(.REF_W(REF_W), .PERIOD(PERIOD), .DEAD(DEAD)) i_lspwm7_gate_gen (
    .clk(clk), .rst(rst), .ref_sample(ref_s),
    .seg_gate(seg_gate), .bridge_gate(bridge_gate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Level code from the stacked-carrier rule of R2.
  function automatic int exp_level(input int v, input int c);
    int mag, t, lvl;
    mag = (v < 0) ? -v : v;
    t   = (c <= HALF) ? c : PERIOD - c;
    lvl = 0;
    for (int k = 0; k < 3; k++)
      if (mag * 3 * HALF > (k * HALF + t) * (1 << (REF_W - 1))) lvl++;
    return lvl;
  endfunction

  task automatic t_reset_hold();
    int bad;
    rst   = 1'b1;
    ref_s = 8'sd100;
    wait_cycles(4);
    check(seg_gate == 3'b000 && bridge_gate == 4'b0000, "R1 in reset",
          int'({seg_gate, bridge_gate}), 0);
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < PERIOD - 2; i++) begin
      @(negedge clk);
      if (seg_gate != 3'b000 || bridge_gate != 4'b0000) bad++;
    end
    check(bad == 0, "R1 hold first period", bad, 0);
    wait_cycles(2 * PERIOD + DEAD);
    check(bridge_gate == 4'b1001, "R1 armed afterwards", bridge_gate, 4'b1001);
  endtask

  // Segment on-time over one full carrier period (R2, R3, R4).
  task automatic t_duty(input int v, input string req);
    int got [3];
    int exp [3];
    int multi;
    ref_s = 8'(v);
    wait_cycles(3 * PERIOD + DEAD);
    for (int k = 0; k < 3; k++) begin got[k] = 0; exp[k] = 0; end
    multi = 0;
    for (int c = 0; c < PERIOD; c++) begin
      int l;
      l = exp_level(v, c);
      if (l > 0) exp[l-1]++;
    end
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if ($countones(seg_gate) > 1) multi++;
      for (int k = 0; k < 3; k++) if (seg_gate[k]) got[k]++;
    end
    for (int k = 0; k < 3; k++)
      check(got[k] == exp[k], req, got[k], exp[k]);
    check(multi == 0, "R3 one-hot segments", multi, 0);
  endtask

  task automatic t_steady(input int v, input logic [3:0] exp_br, input string req);
    int bad;
    ref_s = 8'(v);
    wait_cycles(2 * PERIOD + DEAD);
    bad = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (bridge_gate != exp_br) bad++;
    end
    check(bad == 0, req, bridge_gate, exp_br);
    if (v == 0) check(seg_gate == 3'b000, "R6 no segment at level 0", seg_gate, 0);
  endtask

  // Sign reversal at a level that never drops to 0: measure dead gaps (R7).
  task automatic t_flip();
    int gap_a, gap_b, overlap, hi_both;
    ref_s = 8'sd60;
    wait_cycles(2 * PERIOD + DEAD);
    check(bridge_gate == 4'b1001, "R5 before reversal", bridge_gate, 4'b1001);
    ref_s   = -8'sd60;
    gap_a   = 0;
    gap_b   = 0;
    overlap = 0;
    hi_both = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bridge_gate[1:0] == 2'b00) gap_a++;
      if (bridge_gate[3:2] == 2'b00) gap_b++;
      if (bridge_gate[1:0] == 2'b11 || bridge_gate[3:2] == 2'b11) overlap++;
      if (bridge_gate[0] && bridge_gate[2]) hi_both++;
    end
    check(gap_a == DEAD, "R7 leg A dead gap", gap_a, DEAD);
    check(gap_b == DEAD, "R7 leg B dead gap", gap_b, DEAD);
    check(overlap == 0, "R7 no leg overlap", overlap, 0);
    check(hi_both == 0, "R8 high sides exclusive", hi_both, 0);
    check(bridge_gate == 4'b0110, "R5 after reversal", bridge_gate, 4'b0110);
  endtask

  initial begin
    t_reset_hold();
    t_duty(20,   "R2 low band only");
    t_duty(60,   "R2 two bands");
    t_duty(100,  "R2 three bands");
    t_duty(127,  "R2 near full scale");
    t_duty(-60,  "R4 mirrored sample");
    t_duty(-128, "R4 most negative code");
    t_duty(0,    "R2 zero sample");
    t_steady(60,  4'b1001, "R5 positive diagonal");
    t_steady(-60, 4'b0110, "R5 negative diagonal");
    t_steady(0,   4'b1010, "R6 zero state");
    t_flip();
    finish_run();
  end

endmodule